// File: doc/BRIEF.md
# Byte-Order Data Buffer

This block is the four-byte data buffer that sits between a 16-bit register port and the sequencer that drives bytes onto and off a serial bus. Software writes halfwords, or a single byte as the last write, for transmission. It reads received data back as halfwords. A big-endian mode input chooses how the two bytes of a halfword map onto the order of the bytes on the wire.

Storage is one 32-bit shift register that both directions share, with separate transmit and receive fill counts. Writes shift data in from the low end, and the sequencer pops transmit bytes from the upper filled position. Received bytes land at the position given by the receive count, and reads shift consumed halfwords out towards the low end.

The block does not hold the status flags itself. It reports one-cycle set and clear events, which the flag register owner applies: single-byte read, transmit underflow clear, transmit ready clear, receive ready clear, overrun clear, access-ready set and end of master mode. All event outputs and the read data are registered. They appear in the cycle after the access that caused them.

Top module: `xfer_byte_buffer`

## Requirements
- R1: After reset both fill counts are 0, the read data is 0, the transmit byte output is 0 and every event output is low.
- R2: A halfword write (size_i=1) is dropped when more than 2 transmit bytes are held, and then it raises no event. Otherwise the buffer shifts up by 16 bits and the transmit count rises by 2. An accepted write pulses tx_underflow_clr_o. It also pulses tx_ready_clr_o when the count plus the written bytes exceeds 2.
- R3: tx_byte_o is the byte at position (transmit count minus 1), or 0 when the count is 0. With big_endian_i=1 a halfword write sends wdata_i[15:8] first. With big_endian_i=0 it sends wdata_i[7:0] first.
- R4: A byte write (size_i=0) is dropped when more than 2 transmit bytes are held. Otherwise the buffer shifts up by 8 bits, wdata_i[7:0] enters position 0 and the count rises by 1. It raises the same events as R2.
- R5: tx_pop_i lowers the transmit count by 1. It is ignored when the count is 0.
- R6: A pushed receive byte is stored at the position equal to the receive count after any read in the same cycle, and the count rises by 1. The push is ignored when that count is 4.
- R7: A read returns buffer bytes 0 and 1. Byte 0 is placed in rdata_o[15:8] when big_endian_i=1 and in rdata_o[7:0] otherwise.
- R8: A read with exactly 1 byte held pulses single_byte_set_o and empties the count. With 2 or more bytes held, the buffer shifts down 16 bits only when more than 2 are held, and the count falls by 2.
- R9: Every read pulses rx_overrun_clr_o. A read that leaves the receive count at 0 pulses rx_ready_clr_o. If master_i=1 and rx_mode_i=1, it also pulses access_ready_set_o and master_end_o.
- R10: A read with the buffer empty returns 0 and leaves both counts unchanged.
- R11: When wr_en_i and rd_en_i are both high, the write is performed and the read is ignored: no read events, and rdata_o holds its value.
- R12: A pop in the same cycle as an accepted write yields count+added-1 and keeps the wire order. A push in the same cycle as a read lands after the read's shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| big_endian_i | input | 1 | 1: high byte of a halfword is first on the wire |
| master_i | input | 1 | Controller is in master mode |
| rx_mode_i | input | 1 | 1: transfer direction is receive |
| wr_en_i | input | 1 | Data register write strobe |
| rd_en_i | input | 1 | Data register read strobe |
| size_i | input | 1 | Write size, 1 halfword, 0 byte |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| tx_pop_i | input | 1 | Sequencer takes the next transmit byte |
| tx_byte_o | output | 8 | Next transmit byte |
| tx_count_o | output | 3 | Transmit bytes held |
| rx_push_i | input | 1 | Sequencer delivers a received byte |
| rx_byte_i | input | 8 | Received byte |
| rx_count_o | output | 3 | Receive bytes held |
| single_byte_set_o | output | 1 | Event: read found exactly one byte |
| tx_underflow_clr_o | output | 1 | Event: clear transmit underflow |
| tx_ready_clr_o | output | 1 | Event: clear transmit ready |
| rx_ready_clr_o | output | 1 | Event: clear receive ready |
| rx_overrun_clr_o | output | 1 | Event: clear receive overrun |
| access_ready_set_o | output | 1 | Event: set access ready |
| master_end_o | output | 1 | Event: leave master mode |

## Verification
The sequencer side and the register side can act in the same cycle. A pop can coincide with a data write, and a receive push can coincide with a data read. The bench forces both pairings on purpose: a pop alongside a halfword write to a one-byte buffer, and a push alongside a read of a full four-byte buffer. A behavioural byte-array model steps every cycle and is compared on the following cycle. It checks that the popped byte keeps its place in the wire order and that the pushed byte lands at the post-read position. A write and read strobed together is also applied, to confirm that the write wins.

// File: rtl/xbb_pkg.sv
package xbb_pkg;
  localparam int unsigned XBB_BYTE_W = 8;
  localparam int unsigned XBB_LANES  = 4;

  typedef enum logic {
    XBB_SZ_BYTE = 1'b0,
    XBB_SZ_HALF = 1'b1
  } xbb_size_e;
endpackage

// File: rtl/xbb_lane_order.sv
module xbb_lane_order #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic [2*BYTE_W-1:0] word_i,
  input  logic                swap_i,
  output logic [2*BYTE_W-1:0] word_o
);
  localparam int unsigned NLANE = 2;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign word_o[g*BYTE_W +: BYTE_W] =
      swap_i ? word_i[(NLANE-1-g)*BYTE_W +: BYTE_W] : word_i[g*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/xbb_tx_ctrl.sv
module xbb_tx_ctrl #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned CNT_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic                    half_i,
  input  logic                    pop_i,
  input  logic [LANES*BYTE_W-1:0] buf_i,
  output logic                    wr_ok_o,
  output logic [CNT_W-1:0]        count_o,
  output logic [BYTE_W-1:0]       byte_o,
  output logic                    udf_clr_o,
  output logic                    rdy_clr_o
);
  localparam int unsigned LIMIT = LANES - 2;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [CNT_W-1:0]  add;
  logic              pop_ok;
  logic              cnt_en;
  logic              udf_q, udf_d;
  logic              rdy_q, rdy_d;
  logic [BYTE_W-1:0] lane [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = buf_i[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    wr_ok_o = wr_en_i && (cnt_q <= CNT_W'(LIMIT));
    pop_ok  = pop_i && (cnt_q != '0);
    if (!wr_ok_o)    add = '0;
    else if (half_i) add = CNT_W'(2);
    else             add = CNT_W'(1);
    cnt_d   = cnt_q + add - CNT_W'(pop_ok);
    cnt_en  = wr_ok_o || pop_ok;
    udf_d   = wr_ok_o;
    rdy_d   = wr_ok_o && ((cnt_q + add) > CNT_W'(LIMIT));
  end

  always_comb begin
    byte_o = '0;
    for (int i = 0; i < LANES; i++) begin
      if (cnt_q == CNT_W'(i + 1)) byte_o = lane[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      udf_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      udf_q <= udf_d;
      rdy_q <= rdy_d;
    end
  end

  assign count_o   = cnt_q;
  assign udf_clr_o = udf_q;
  assign rdy_clr_o = rdy_q;

  p_tx_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LANES));

  p_drop_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && cnt_q > CNT_W'(LIMIT) && !pop_i) |=> (cnt_q == $past(cnt_q)) && !udf_q);

  p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && cnt_q == '0 && !wr_en_i) |=> (cnt_q == '0));

  p_half_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && half_i && cnt_q <= CNT_W'(LIMIT) && !pop_i) |=> (cnt_q == $past(cnt_q) + CNT_W'(2)));
endmodule

// File: rtl/xbb_rx_ctrl.sv
module xbb_rx_ctrl #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = 4,
  parameter int unsigned CNT_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_i,
  input  logic                push_i,
  input  logic                master_i,
  input  logic                rx_mode_i,
  input  logic [2*BYTE_W-1:0] rd_word_i,
  output logic [CNT_W-1:0]    after_o,
  output logic                shift_o,
  output logic                push_ok_o,
  output logic [CNT_W-1:0]    count_o,
  output logic [2*BYTE_W-1:0] rdata_o,
  output logic                sbd_set_o,
  output logic                rovr_clr_o,
  output logic                rrdy_clr_o,
  output logic                ardy_set_o,
  output logic                mst_end_o
);
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic                cnt_en;
  logic [2*BYTE_W-1:0] rdata_q, rdata_d;
  logic                sbd_q, sbd_d;
  logic                rovr_q, rovr_d;
  logic                rrdy_q, rrdy_d;
  logic                ardy_q, ardy_d;
  logic                mst_q, mst_d;

  always_comb begin
    if (!rd_i)                    after_o = cnt_q;
    else if (cnt_q <= CNT_W'(1))  after_o = '0;
    else                          after_o = cnt_q - CNT_W'(2);
    shift_o   = rd_i && (cnt_q > CNT_W'(2));
    push_ok_o = push_i && (after_o < CNT_W'(LANES));
    cnt_d     = after_o + CNT_W'(push_ok_o);
    cnt_en    = rd_i || push_ok_o;
    rdata_d   = (cnt_q == '0) ? '0 : rd_word_i;
    sbd_d     = rd_i && (cnt_q == CNT_W'(1));
    rovr_d    = rd_i;
    rrdy_d    = rd_i && (after_o == '0);
    ardy_d    = rrdy_d && master_i && rx_mode_i;
    mst_d     = ardy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      rdata_q <= '0;
      sbd_q   <= 1'b0;
      rovr_q  <= 1'b0;
      rrdy_q  <= 1'b0;
      ardy_q  <= 1'b0;
      mst_q   <= 1'b0;
    end else begin
      if (cnt_en) cnt_q   <= cnt_d;
      if (rd_i)   rdata_q <= rdata_d;
      sbd_q  <= sbd_d;
      rovr_q <= rovr_d;
      rrdy_q <= rrdy_d;
      ardy_q <= ardy_d;
      mst_q  <= mst_d;
    end
  end

  assign count_o    = cnt_q;
  assign rdata_o    = rdata_q;
  assign sbd_set_o  = sbd_q;
  assign rovr_clr_o = rovr_q;
  assign rrdy_clr_o = rrdy_q;
  assign ardy_set_o = ardy_q;
  assign mst_end_o  = mst_q;

  p_rx_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LANES));

  p_single_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && cnt_q == CNT_W'(1) && !push_i) |=> (sbd_q && cnt_q == '0));

  p_read_clears_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_i |=> rovr_q);

  p_empty_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && cnt_q == '0 && !push_i) |=> (cnt_q == '0 && rdata_q == '0));

  p_ardy_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ardy_q |-> (rrdy_q && rovr_q));
endmodule

// File: rtl/xfer_byte_buffer.sv
module xfer_byte_buffer #(
  parameter int unsigned BYTE_W = xbb_pkg::XBB_BYTE_W,
  parameter int unsigned LANES  = xbb_pkg::XBB_LANES,
  parameter int unsigned CNT_W  = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                big_endian_i,
  input  logic                master_i,
  input  logic                rx_mode_i,
  input  logic                wr_en_i,
  input  logic                rd_en_i,
  input  logic                size_i,
  input  logic [2*BYTE_W-1:0] wdata_i,
  output logic [2*BYTE_W-1:0] rdata_o,
  input  logic                tx_pop_i,
  output logic [BYTE_W-1:0]   tx_byte_o,
  output logic [CNT_W-1:0]    tx_count_o,
  input  logic                rx_push_i,
  input  logic [BYTE_W-1:0]   rx_byte_i,
  output logic [CNT_W-1:0]    rx_count_o,
  output logic                single_byte_set_o,
  output logic                tx_underflow_clr_o,
  output logic                tx_ready_clr_o,
  output logic                rx_ready_clr_o,
  output logic                rx_overrun_clr_o,
  output logic                access_ready_set_o,
  output logic                master_end_o
);
  import xbb_pkg::*;

  localparam int unsigned HALF_W = 2 * BYTE_W;
  localparam int unsigned BUF_W  = LANES * BYTE_W;

  logic [BUF_W-1:0]  buf_q, buf_d;
  logic              buf_en;
  logic [HALF_W-1:0] wr_word, rd_word;
  logic              rd_act;
  logic              wr_ok;
  logic              is_half;
  logic [CNT_W-1:0]  rx_after;
  logic              rd_shift;
  logic              push_ok;

  assign rd_act  = rd_en_i && !wr_en_i;
  assign is_half = (xbb_size_e'(size_i) == XBB_SZ_HALF);

  xbb_lane_order #(.BYTE_W(BYTE_W)) i_wr_order (
    .word_i (wdata_i),
    .swap_i (!big_endian_i),
    .word_o (wr_word)
  );

  xbb_lane_order #(.BYTE_W(BYTE_W)) i_rd_order (
    .word_i (buf_q[HALF_W-1:0]),
    .swap_i (big_endian_i),
    .word_o (rd_word)
  );

  xbb_tx_ctrl #(.BYTE_W(BYTE_W), .LANES(LANES), .CNT_W(CNT_W)) i_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .half_i    (is_half),
    .pop_i     (tx_pop_i),
    .buf_i     (buf_q),
    .wr_ok_o   (wr_ok),
    .count_o   (tx_count_o),
    .byte_o    (tx_byte_o),
    .udf_clr_o (tx_underflow_clr_o),
    .rdy_clr_o (tx_ready_clr_o)
  );

  xbb_rx_ctrl #(.BYTE_W(BYTE_W), .LANES(LANES), .CNT_W(CNT_W)) i_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_i       (rd_act),
    .push_i     (rx_push_i),
    .master_i   (master_i),
    .rx_mode_i  (rx_mode_i),
    .rd_word_i  (rd_word),
    .after_o    (rx_after),
    .shift_o    (rd_shift),
    .push_ok_o  (push_ok),
    .count_o    (rx_count_o),
    .rdata_o    (rdata_o),
    .sbd_set_o  (single_byte_set_o),
    .rovr_clr_o (rx_overrun_clr_o),
    .rrdy_clr_o (rx_ready_clr_o),
    .ardy_set_o (access_ready_set_o),
    .mst_end_o  (master_end_o)
  );

  always_comb begin
    buf_d = buf_q;
    if (wr_ok) begin
      if (is_half) buf_d = {buf_q[BUF_W-HALF_W-1:0], wr_word};
      else         buf_d = {buf_q[BUF_W-BYTE_W-1:0], wdata_i[BYTE_W-1:0]};
    end else if (rd_shift) begin
      buf_d = buf_q >> HALF_W;
    end
    for (int i = 0; i < LANES; i++) begin
      if (push_ok && rx_after == CNT_W'(i)) buf_d[i*BYTE_W +: BYTE_W] = rx_byte_i;
    end
    buf_en = wr_ok || rd_shift || push_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '0;
    else if (buf_en) buf_q <= buf_d;
  end

  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && rd_en_i) |=> (!rx_overrun_clr_o && $stable(rdata_o)));

  p_pop_with_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && size_i && tx_pop_i && tx_count_o == CNT_W'(1))
      |=> (tx_count_o == CNT_W'(2)));

  p_push_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push_i && !rd_en_i && !wr_en_i && rx_count_o < CNT_W'(LANES))
      |=> (rx_count_o == $past(rx_count_o) + CNT_W'(1)));
endmodule

// File: tb/test_xfer_byte_buffer.sv
module test_xfer_byte_buffer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        big_endian_i, master_i, rx_mode_i;
  logic        wr_en_i, rd_en_i, size_i;
  logic [15:0] wdata_i;
  logic [15:0] rdata_o;
  logic        tx_pop_i;
  logic [7:0]  tx_byte_o;
  logic [2:0]  tx_count_o;
  logic        rx_push_i;
  logic [7:0]  rx_byte_i;
  logic [2:0]  rx_count_o;
  logic        single_byte_set_o, tx_underflow_clr_o, tx_ready_clr_o;
  logic        rx_ready_clr_o, rx_overrun_clr_o, access_ready_set_o, master_end_o;

  int vectors = 0;
  int miscompares = 0;

  // behavioural model state
  logic [7:0]  mb [4];
  int          m_tx, m_rx;
  logic [15:0] m_rdata;
  logic        e_sbd, e_udf, e_xrdy, e_rrdy, e_rovr, e_ardy, e_mst;

  always #4 clk = ~clk;

  xfer_byte_buffer i_xfer_byte_buffer (
    .clk(clk), .rst_n(rst_n), .big_endian_i(big_endian_i), .master_i(master_i),
    .rx_mode_i(rx_mode_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .size_i(size_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tx_pop_i(tx_pop_i), .tx_byte_o(tx_byte_o),
    .tx_count_o(tx_count_o), .rx_push_i(rx_push_i), .rx_byte_i(rx_byte_i),
    .rx_count_o(rx_count_o), .single_byte_set_o(single_byte_set_o),
    .tx_underflow_clr_o(tx_underflow_clr_o), .tx_ready_clr_o(tx_ready_clr_o),
    .rx_ready_clr_o(rx_ready_clr_o), .rx_overrun_clr_o(rx_overrun_clr_o),
    .access_ready_set_o(access_ready_set_o), .master_end_o(master_end_o)
  );

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    int exp_byte;
    exp_byte = (m_tx > 0) ? int'(mb[m_tx-1]) : 0;
    vectors++;
    cmp(tag, "rdata", int'(rdata_o), int'(m_rdata));
    cmp(tag, "tx_byte", int'(tx_byte_o), exp_byte);
    cmp(tag, "tx_count", int'(tx_count_o), m_tx);
    cmp(tag, "rx_count", int'(rx_count_o), m_rx);
    cmp(tag, "single_byte", int'(single_byte_set_o), int'(e_sbd));
    cmp(tag, "udf_clr", int'(tx_underflow_clr_o), int'(e_udf));
    cmp(tag, "txrdy_clr", int'(tx_ready_clr_o), int'(e_xrdy));
    cmp(tag, "rxrdy_clr", int'(rx_ready_clr_o), int'(e_rrdy));
    cmp(tag, "ovr_clr", int'(rx_overrun_clr_o), int'(e_rovr));
    cmp(tag, "ardy_set", int'(access_ready_set_o), int'(e_ardy));
    cmp(tag, "mst_end", int'(master_end_o), int'(e_mst));
  endtask

  // apply one cycle of stimulus, advance model, compare after the edge
  task automatic step(input string tag, input logic wr, input logic rd, input logic half,
                      input logic [15:0] wd, input logic pop, input logic push,
                      input logic [7:0] rb);
    int  add, pos, old_rx;
    bit  rd_go, wr_go;
    @(negedge clk);
    wr_en_i = wr; rd_en_i = rd; size_i = half; wdata_i = wd;
    tx_pop_i = pop; rx_push_i = push; rx_byte_i = rb;
    e_sbd = 0; e_udf = 0; e_xrdy = 0; e_rrdy = 0; e_rovr = 0; e_ardy = 0; e_mst = 0;
    wr_go = wr && (m_tx <= 2);
    rd_go = rd && !wr;
    add = wr_go ? (half ? 2 : 1) : 0;
    if (wr_go) begin
      e_udf  = 1;
      e_xrdy = (m_tx + add) > 2;
      if (half) begin
        mb[3] = mb[1]; mb[2] = mb[0];
        if (big_endian_i) begin mb[1] = wd[15:8]; mb[0] = wd[7:0]; end
        else              begin mb[1] = wd[7:0];  mb[0] = wd[15:8]; end
      end else begin
        mb[3] = mb[2]; mb[2] = mb[1]; mb[1] = mb[0]; mb[0] = wd[7:0];
      end
    end
    m_tx = m_tx + add - ((pop && m_tx > 0) ? 1 : 0);
    old_rx = m_rx;
    if (rd_go) begin
      e_rovr = 1;
      if (old_rx == 0) m_rdata = 16'h0;
      else m_rdata = big_endian_i ? {mb[0], mb[1]} : {mb[1], mb[0]};
      if (old_rx == 1) begin e_sbd = 1; m_rx = 0; end
      else if (old_rx > 1) begin
        if (old_rx > 2) begin mb[0] = mb[2]; mb[1] = mb[3]; mb[2] = 0; mb[3] = 0; end
        m_rx = old_rx - 2;
      end
      if (m_rx == 0) begin
        e_rrdy = 1;
        if (master_i && rx_mode_i) begin e_ardy = 1; e_mst = 1; end
      end
    end
    if (push && m_rx < 4) begin
      pos = m_rx;
      mb[pos] = rb;
      m_rx++;
    end
    @(posedge clk);
    #1;
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 16'h0, 0, 0, 8'h0);
  endtask

  initial begin
    #1_600_000;
    miscompares++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    big_endian_i = 1; master_i = 0; rx_mode_i = 0;
    wr_en_i = 0; rd_en_i = 0; size_i = 0; wdata_i = '0;
    tx_pop_i = 0; rx_push_i = 0; rx_byte_i = '0;
    for (int i = 0; i < 4; i++) mb[i] = 8'h0;
    m_tx = 0; m_rx = 0; m_rdata = 16'h0;
    e_sbd = 0; e_udf = 0; e_xrdy = 0; e_rrdy = 0; e_rovr = 0; e_ardy = 0; e_mst = 0;
    repeat (3) @(posedge clk);
    #1;
    compare_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    idle("R1");

    // big-endian transmit: high byte first
    step("R2", 1, 0, 1, 16'hA1B2, 0, 0, 8'h0);
    step("R2", 1, 0, 1, 16'hC3D4, 0, 0, 8'h0);
    step("R2", 1, 0, 1, 16'hEEFF, 0, 0, 8'h0);   // dropped, 4 held
    step("R4", 1, 0, 0, 16'h0055, 0, 0, 8'h0);   // dropped byte
    for (int k = 0; k < 4; k++) step("R3", 0, 0, 0, 16'h0, 1, 0, 8'h0);
    step("R5", 0, 0, 0, 16'h0, 1, 0, 8'h0);       // pop on empty

    // little-endian transmit plus final byte
    big_endian_i = 0;
    step("R3", 1, 0, 1, 16'h1122, 0, 0, 8'h0);
    step("R4", 1, 0, 0, 16'h7733, 0, 0, 8'h0);
    step("R4", 1, 0, 0, 16'h0044, 0, 0, 8'h0);   // dropped, 3 held
    step("R5", 0, 0, 0, 16'h0, 1, 0, 8'h0);
    step("R5", 0, 0, 0, 16'h0, 1, 0, 8'h0);
    // pop with write in one cycle: 1 held
    step("R12", 1, 0, 1, 16'h5566, 1, 0, 8'h0);
    step("R12", 0, 0, 0, 16'h0, 1, 0, 8'h0);
    step("R12", 0, 0, 0, 16'h0, 1, 0, 8'h0);
    step("R5", 0, 0, 0, 16'h0, 1, 0, 8'h0);

    // receive path
    master_i = 1; rx_mode_i = 1;
    step("R10", 0, 1, 0, 16'h0, 0, 0, 8'h0);     // empty read
    step("R6", 0, 0, 0, 16'h0, 0, 1, 8'h10);
    step("R6", 0, 0, 0, 16'h0, 0, 1, 8'h20);
    step("R6", 0, 0, 0, 16'h0, 0, 1, 8'h30);
    step("R6", 0, 0, 0, 16'h0, 0, 1, 8'h40);
    step("R6", 0, 0, 0, 16'h0, 0, 1, 8'h50);     // full, ignored
    step("R7", 0, 1, 0, 16'h0, 0, 0, 8'h0);      // LE read, shift
    big_endian_i = 1;
    step("R9", 0, 1, 0, 16'h0, 0, 0, 8'h0);      // BE read empties, master rx
    step("R8", 0, 0, 0, 16'h0, 0, 1, 8'h61);
    step("R8", 0, 1, 0, 16'h0, 0, 0, 8'h0);      // single byte read
    // read with push in one cycle on full buffer
    for (int k = 0; k < 4; k++) step("R6", 0, 0, 0, 16'h0, 0, 1, 8'h70 + 8'(k));
    step("R12", 0, 1, 0, 16'h0, 0, 1, 8'h7F);
    step("R11", 1, 1, 1, 16'h9988, 0, 0, 8'h0);  // write wins
    master_i = 0;
    step("R9", 0, 1, 0, 16'h0, 0, 0, 8'h0);
    step("R9", 0, 1, 0, 16'h0, 0, 0, 8'h0);
    step("R10", 0, 1, 0, 16'h0, 0, 0, 8'h0);
    idle("R1");

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule